// File: doc/BRIEF.md
# Register-Operand Integer ALU

A purely combinational 32-bit arithmetic and logic unit for a three-operand load/store processor's execute stage. Each cycle it takes two register operands, a 5-bit constant shift amount and a 5-bit operation code. It returns a 32-bit result and a flag that asks the surrounding pipeline to raise an overflow exception.

The operations are:
- add and subtract, each in a trapping and a non-trapping form;
- bitwise AND, OR, XOR and NOR;
- signed and unsigned set-on-less-than;
- logical-left, logical-right and arithmetic-right shifts, each by a constant or by a register amount;
- placing a 16-bit constant in the upper half of the word.

For shifts, the value shifted is the second operand. A variable shift takes its amount from the first operand. The upper-half placement takes its constant from the low 16 bits of the second operand.

A single shared adder serves the add, subtract and both compares. The result port always carries the wrapped value, and the flag alone decides whether the destination write is suppressed.

Top module: `alu_core`

## Requirements
- R1: Op code 0 (trapping add) and op code 1 (non-trapping add) drive res_o with opa_i + opb_i modulo 2^32.
- R2: Op code 2 (trapping subtract) and op code 3 (non-trapping subtract) drive res_o with opa_i - opb_i modulo 2^32.
- R3: ovf_o is 1 only for op codes 0 and 2, and only when the exact two's-complement result falls outside the signed 32-bit range. In every other case it is 0.
- R4: When ovf_o is 1, res_o still carries the wrapped 32-bit sum or difference.
- R5: Op codes 4, 5, 6 and 7 give the bitwise AND, OR, XOR and NOR (the inverted OR) of opa_i and opb_i.
- R6: Op code 8 gives 1 when opa_i < opb_i as two's-complement numbers, and 0 otherwise. Bits 31:1 are zero.
- R7: Op code 9 gives 1 when opa_i < opb_i as unsigned numbers, and 0 otherwise. Bits 31:1 are zero.
- R8: Op codes 10 (shift left) and 11 (shift right) shift opb_i by shamt_i and fill vacated bits with zeros. An amount of 0 returns opb_i unchanged.
- R9: Op code 12 shifts opb_i right by shamt_i and fills vacated bits with copies of opb_i[31].
- R10: Op codes 13, 14 and 15 perform the left, right and arithmetic-right shifts of opb_i by opa_i[4:0]. Bits 31:5 of opa_i have no effect.
- R11: Op code 16 drives res_o with {opb_i[15:0], 16'h0000}.
- R12: Op codes 17 to 31 drive res_o to 0 and ovf_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | 32 | First operand; supplies the amount for variable shifts |
| opb_i | input | 32 | Second operand; value shifted, and source of the upper-half constant |
| shamt_i | input | 5 | Constant shift amount |
| op_i | input | 5 | Operation code |
| res_o | output | 32 | Result |
| ovf_o | output | 1 | Signed overflow, trapping add/subtract only |

## Verification
The overflow flag and the wrapped result are produced in the same evaluation. For a trapping add or subtract that overflows, both must be correct together. The bench provokes this with operand pairs at the signed limits, such as 0x7fffffff plus 1 and 0x80000000 minus 1. On every such cycle it compares the flag and the wrapped value against a model that works in 64-bit integers. The same pairs are then applied with the non-trapping codes, where the result must be unchanged and the flag must stay low.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned OP_W   = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,
    OP_ADDU = 5'd1,
    OP_SUB  = 5'd2,
    OP_SUBU = 5'd3,
    OP_AND  = 5'd4,
    OP_OR   = 5'd5,
    OP_XOR  = 5'd6,
    OP_NOR  = 5'd7,
    OP_SLT  = 5'd8,
    OP_SLTU = 5'd9,
    OP_SLL  = 5'd10,
    OP_SRL  = 5'd11,
    OP_SRA  = 5'd12,
    OP_SLLV = 5'd13,
    OP_SRLV = 5'd14,
    OP_SRAV = 5'd15,
    OP_LUI  = 5'd16
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_NOR = 2'd3
  } logic_sel_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o,
  output logic             ovf_o
);
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   full;

  assign b_eff   = b_i ^ {WIDTH{sub_i}};
  assign full    = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_i};
  assign sum_o   = full[WIDTH-1:0];
  assign carry_o = full[WIDTH];
  // operands of the effective add agree in sign, result sign differs
  assign ovf_o   = (a_i[WIDTH-1] == b_eff[WIDTH-1]) && (sum_o[WIDTH-1] != a_i[WIDTH-1]);
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic_sel_e       sel_i,
  output logic [WIDTH-1:0] y_o
);
  always_comb begin
    unique case (sel_i)
      LG_AND:  y_o = a_i & b_i;
      LG_OR:   y_o = a_i | b_i;
      LG_XOR:  y_o = a_i ^ b_i;
      default: y_o = ~(a_i | b_i);
    endcase
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic             right_i,
  input  logic             arith_i,
  output logic [WIDTH-1:0] y_o
);
  logic [WIDTH-1:0] rev_in;
  logic [WIDTH-1:0] rev_out;
  logic [WIDTH-1:0] stage [AMT_W+1];
  logic             fill;

  // left shifts reuse the right shifter on a bit-reversed word
  for (genvar i = 0; i < WIDTH; i++) begin : g_rev
    assign rev_in[i]  = data_i[WIDTH-1-i];
    assign rev_out[i] = stage[AMT_W][WIDTH-1-i];
  end

  assign fill     = right_i & arith_i & data_i[WIDTH-1];
  assign stage[0] = right_i ? data_i : rev_in;

  for (genvar s = 0; s < AMT_W; s++) begin : g_stage
    localparam int unsigned STEP = 1 << s;
    assign stage[s+1] = amt_i[s]
      ? {{STEP{fill}}, stage[s][WIDTH-1:STEP]}
      : stage[s];
  end

  assign y_o = right_i ? stage[AMT_W] : rev_out;
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
(
  input  logic [31:0] opa_i,
  input  logic [31:0] opb_i,
  input  logic [4:0]  shamt_i,
  input  logic [4:0]  op_i,
  output logic [31:0] res_o,
  output logic        ovf_o
);
  localparam int unsigned W     = DATA_W;
  localparam int unsigned AMT_W = $clog2(W);
  localparam int unsigned HALF  = W / 2;

  alu_op_e    op;
  logic       sub;
  logic       trap;
  logic [W-1:0] sum;
  logic       carry;
  logic       add_ovf;
  logic [W-1:0] lg_y;
  logic_sel_e lg_sel;
  logic [W-1:0] sh_y;
  logic [AMT_W-1:0] sh_amt;
  logic       sh_right;
  logic       sh_arith;
  logic       lt_s;
  logic       lt_u;

  assign op = alu_op_e'(op_i);

  assign sub  = (op == OP_SUB) || (op == OP_SUBU) || (op == OP_SLT) || (op == OP_SLTU);
  assign trap = (op == OP_ADD) || (op == OP_SUB);

  alu_addsub #(.WIDTH(W)) u_addsub (
    .a_i    (opa_i),
    .b_i    (opb_i),
    .sub_i  (sub),
    .sum_o  (sum),
    .carry_o(carry),
    .ovf_o  (add_ovf)
  );

  // compares reuse the subtract: signed via sign^ovf, unsigned via borrow
  assign lt_s = sum[W-1] ^ add_ovf;
  assign lt_u = ~carry;

  assign lg_sel = logic_sel_e'(op_i[1:0]);

  alu_logic #(.WIDTH(W)) u_logic (
    .a_i  (opa_i),
    .b_i  (opb_i),
    .sel_i(lg_sel),
    .y_o  (lg_y)
  );

  always_comb begin
    sh_amt   = shamt_i;
    sh_right = 1'b0;
    sh_arith = 1'b0;
    unique case (op)
      OP_SRL:  sh_right = 1'b1;
      OP_SRA:  begin sh_right = 1'b1; sh_arith = 1'b1; end
      OP_SLLV: sh_amt = opa_i[AMT_W-1:0];
      OP_SRLV: begin sh_amt = opa_i[AMT_W-1:0]; sh_right = 1'b1; end
      OP_SRAV: begin sh_amt = opa_i[AMT_W-1:0]; sh_right = 1'b1; sh_arith = 1'b1; end
      default: ;
    endcase
  end

  alu_shifter #(.WIDTH(W)) u_shift (
    .data_i (opb_i),
    .amt_i  (sh_amt),
    .right_i(sh_right),
    .arith_i(sh_arith),
    .y_o    (sh_y)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_ADDU, OP_SUB, OP_SUBU:  res_o = sum;
      OP_AND, OP_OR, OP_XOR, OP_NOR:     res_o = lg_y;
      OP_SLT:                            res_o = {{(W-1){1'b0}}, lt_s};
      OP_SLTU:                           res_o = {{(W-1){1'b0}}, lt_u};
      OP_SLL, OP_SRL, OP_SRA,
      OP_SLLV, OP_SRLV, OP_SRAV:         res_o = sh_y;
      OP_LUI:                            res_o = {opb_i[HALF-1:0], {HALF{1'b0}}};
      default:                           res_o = '0;
    endcase
  end

  assign ovf_o = trap & add_ovf;
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk (
  input logic [31:0] opa_i,
  input logic [31:0] opb_i,
  input logic [4:0]  shamt_i,
  input logic [4:0]  op_i,
  input logic [31:0] res_o,
  input logic        ovf_o
);
  always_comb begin
    if (op_i != 5'd0 && op_i != 5'd2) begin
      assert_no_overflow_R3: assert (!ovf_o) else $error("ovf on non-trapping op");
    end
    if (op_i == 5'd8 || op_i == 5'd9) begin
      assert_slt_upper_zero_R6: assert (res_o[31:1] == 31'd0) else $error("compare upper bits");
    end
    if (op_i == 5'd10 && shamt_i == 5'd0) begin
      assert_sll_zero_identity_R8: assert (res_o == opb_i) else $error("zero shift changed value");
    end
    if (op_i == 5'd12 && opb_i[31]) begin
      assert_sra_sign_R9: assert (res_o[31]) else $error("sra lost sign");
    end
    if (op_i == 5'd16) begin
      assert_lui_low_zero_R11: assert (res_o[15:0] == 16'd0) else $error("lui low half");
    end
    if (op_i > 5'd16) begin
      assert_unused_zero_R12: assert (res_o == 32'd0 && !ovf_o) else $error("unused op output");
    end
    if (op_i == 5'd1 && opa_i == 32'd0) begin
      assert_addu_identity_R1: assert (res_o == opb_i) else $error("add of zero");
    end
  end
endmodule

bind alu_core alu_core_chk u_chk (.*);

// File: tb/alu_core_tb.sv
module alu_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] opa, opb;
  logic [4:0]  shamt, op;
  logic [31:0] res;
  logic        ovf;
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  alu_core u_dut (
    .opa_i  (opa),
    .opb_i  (opb),
    .shamt_i(shamt),
    .op_i   (op),
    .res_o  (res),
    .ovf_o  (ovf)
  );

  function automatic void model(input logic [4:0] o, input logic [31:0] a, input logic [31:0] b,
                                input logic [4:0] s, output logic [31:0] r, output logic v);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint x;
    int n;
    r = 32'd0;
    v = 1'b0;
    case (o)
      0, 1: begin x = sa + sb; r = a + b; v = (o == 0) && (x > 64'sd2147483647 || x < -64'sd2147483648); end
      2, 3: begin x = sa - sb; r = a - b; v = (o == 2) && (x > 64'sd2147483647 || x < -64'sd2147483648); end
      4: r = a & b;
      5: r = a | b;
      6: r = a ^ b;
      7: r = ~(a | b);
      8: r = (sa < sb) ? 32'd1 : 32'd0;
      9: r = (a < b) ? 32'd1 : 32'd0;
      10, 13: begin n = (o == 10) ? int'(s) : int'(a % 32); r = b << n; end
      11, 14: begin n = (o == 11) ? int'(s) : int'(a % 32); r = b >> n; end
      12, 15: begin n = (o == 12) ? int'(s) : int'(a % 32); r = $unsigned($signed(b) >>> n); end
      16: r = b * 32'd65536;
      default: ;
    endcase
  endfunction

  task automatic run(input logic [4:0] o, input logic [31:0] a, input logic [31:0] b,
                     input logic [4:0] s, input string tag);
    logic [31:0] er;
    logic ev;
    @(negedge clk);
    op = o; opa = a; opb = b; shamt = s;
    model(o, a, b, s, er, ev);
    @(posedge clk);
    #1;
    checks++;
    if (res !== er || ovf !== ev) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h s=%0d: actual res=%h ovf=%b expected res=%h ovf=%b",
               tag, o, a, b, s, res, ovf, er, ev);
    end
  endtask

  initial begin
    while (!done && cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    op = 5'd0; opa = 32'd0; opb = 32'd0; shamt = 5'd0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #1;
    checks++;
    if (res !== 32'd0 || ovf !== 1'b0) begin
      errors++;
      $display("FAIL reset R1: actual res=%h ovf=%b expected 0/0", res, ovf);
    end

    // R1 R2 R3 R4: limits, trapping versus non-trapping
    run(0, 32'h7fffffff, 32'h1, 0, "R3_R4 add ovf");
    run(1, 32'h7fffffff, 32'h1, 0, "R1 addu no ovf");
    run(0, 32'h80000000, 32'h80000000, 0, "R3_R4 add neg ovf");
    run(0, 32'hffffffff, 32'h1, 0, "R1 add carry no ovf");
    run(2, 32'h80000000, 32'h1, 0, "R3_R4 sub ovf");
    run(3, 32'h80000000, 32'h1, 0, "R2 subu no ovf");
    run(2, 32'h7fffffff, 32'hffffffff, 0, "R3 sub pos ovf");
    run(2, 32'h5, 32'h7, 0, "R2 sub");
    // R5
    run(4, 32'hf0f0ff00, 32'h0ff0f0f0, 0, "R5 and");
    run(5, 32'hf0f0ff00, 32'h0ff0f0f0, 0, "R5 or");
    run(6, 32'hf0f0ff00, 32'h0ff0f0f0, 0, "R5 xor");
    run(7, 32'hf0f0ff00, 32'h0ff0f0f0, 0, "R5 nor");
    // R6 R7
    run(8, 32'h2, 32'h1, 0, "R6 slt 2<1");
    run(9, 32'h2, 32'h1, 0, "R7 sltu 2<1");
    run(8, 32'hffffffff, 32'h1, 0, "R6 slt -1<1");
    run(9, 32'hffffffff, 32'h1, 0, "R7 sltu max<1");
    run(8, 32'h7fffffff, 32'h80000000, 0, "R6 slt limits");
    run(9, 32'h7fffffff, 32'h80000000, 0, "R7 sltu limits");
    run(8, 32'h4, 32'h4, 0, "R6 slt equal");
    // R8 R9 R10
    run(10, 32'h0, 32'h80000001, 0, "R8 sll 0");
    run(10, 32'h0, 32'h80000001, 31, "R8 sll 31");
    run(11, 32'h0, 32'h80000001, 31, "R8 srl 31");
    run(12, 32'h0, 32'h80000001, 31, "R9 sra 31");
    run(12, 32'h0, 32'h40000000, 4, "R9 sra pos");
    run(13, 32'hffffffe4, 32'h00000003, 0, "R10 sllv masked");
    run(14, 32'h00000123, 32'hf0000000, 0, "R10 srlv masked");
    run(15, 32'hfffffffc, 32'h80000000, 0, "R10 srav masked");
    // R11 R12
    run(16, 32'hdeadbeef, 32'h1234abcd, 0, "R11 lui");
    run(17, 32'h7fffffff, 32'h1, 0, "R12 unused 17");
    run(31, 32'hffffffff, 32'hffffffff, 31, "R12 unused 31");

    for (int i = 0; i < 600; i++) begin
      logic [31:0] a, b;
      a = $urandom;
      b = $urandom;
      if (i % 5 == 0) a = {a[31], {31{~a[31]}}};
      if (i % 7 == 0) b = {b[31], 31'd0};
      run(5'(i % 32), a, b, 5'($urandom), "R1_R12 random");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule